// File: doc/BRIEF.md
# Daisy-Chain DAC Host Driver

This block sits on the host side of a string of serial 12-bit DACs. The DACs are chained on three shared wires: serial data, a strobe clock and a load line. Every DAC in the chain passes its old word on to the next device while it takes in a new one. To fill N devices, the host therefore shifts N×12 bits as one frame. It sends the word for the farthest device first and the most significant bit of each word first. When the last bit has been strobed in, the host drops the shared load line once so that every channel updates in the same instant.

Software, or a sequencer upstream, writes the words into a small indexed buffer through a valid/ready port. Index 0 is the DAC nearest the host. A start pulse then launches the frame. Three configuration counts set, in system-clock cycles, how long the strobe stays low, how long it stays high between bits and how wide the load pulse is. For a chain wired for bipolar output, an enable input turns two's-complement words into offset binary by flipping each word's top bit as it is sent.

Top module: `dcd_chain_driver`

## Requirements
- R1: After reset, ser_clk and ser_load_n are high, busy is low, wr_ready is high and ser_data is 0.
- R2: A frame has exactly N×12 rising edges of ser_clk. The bit on ser_data at each edge follows the buffer from index N−1 down to index 0, and each word goes out from bit 11 down to bit 0.
- R3: ser_data changes only in cycles in which ser_clk is low.
- R4: Every low phase of ser_clk lasts max(cfg_lo_cycles,1) cycles. Every high phase between two bits lasts max(cfg_hi_cycles,1) cycles.
- R5: ser_load_n falls in the same cycle as the last rising strobe edge of the frame. It stays low for max(cfg_ld_cycles,1) cycles and pulses once per frame.
- R6: busy rises in the cycle after start is sampled while idle and falls as the load pulse ends, so it lasts 12N·lo + (12N−1)·hi + ld cycles. wr_ready is low while busy, and a word write offered while busy leaves the buffer unchanged.
- R7: With bipolar_en high, bit 11 of every word is inverted on the wire and the other bits are unchanged. With bipolar_en low, words go out unchanged.
- R8: A start pulse given while busy neither restarts nor lengthens the frame in progress.
- R9: While busy is low, ser_clk and ser_load_n stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo_cycles | input | 8 | Strobe low time in cycles (0 treated as 1) |
| cfg_hi_cycles | input | 8 | Strobe high time between bits in cycles (0 treated as 1) |
| cfg_ld_cycles | input | 8 | Load pulse width in cycles (0 treated as 1) |
| bipolar_en | input | 1 | Invert bit 11 of each word on the wire |
| wr_valid | input | 1 | Word write request |
| wr_ready | output | 1 | High when a write will be taken (block idle) |
| wr_idx | input | 2 | Buffer index of the word, 0 = nearest DAC |
| wr_word | input | 12 | Word to store |
| start | input | 1 | Launch a frame (taken only when idle) |
| ser_data | output | 1 | Serial data to the first DAC |
| ser_clk | output | 1 | Strobe, data taken on its rising edge, idles high |
| ser_load_n | output | 1 | Shared load, active low |
| busy | output | 1 | Frame in progress |

## Verification
The start pulse is sampled at one clock edge. From that same edge busy is high, ser_clk is low and the first bit is on ser_data. The k-th rising strobe edge (counting from 0) then comes lo + k·(lo+hi) cycles after that edge. The load pulse falls together with the last rise, and busy drops ld cycles later. The bench drives and samples only on falling clock edges and walks the frame one cycle at a time. At each observed rise it captures the bit, and it measures every low, high, load and busy run against the counts those formulas predict. After the frame it checks the idle levels, and it runs a second frame to show that writes and starts offered mid-frame had no effect.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOAD = 2'd3
  } phase_e;

endpackage

// File: rtl/dcd_word_store.sv
module dcd_word_store #(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 12,
  parameter int IDX_W  = 2,
  localparam int FRAME_W = N_DEV * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               bipolar,
  output logic [FRAME_W-1:0] frame_o
);

  // Offset-binary conversion of a two's-complement word: flip the sign bit.
  function automatic logic [WORD_W-1:0] wire_code(input logic [WORD_W-1:0] w,
                                                  input logic            bip);
    wire_code = w ^ {bip, {(WORD_W-1){1'b0}}};
  endfunction

  for (genvar g = 0; g < N_DEV; g++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        word_q <= wr_data;
    end

    // Highest index sits at the top of the frame, so it leaves first.
    assign frame_o[g*WORD_W +: WORD_W] = wire_code(word_q, bipolar);
  end

endmodule

// File: rtl/dcd_frame_shifter.sv
module dcd_frame_shifter #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_en,
  output logic               bit_o
);

  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else if (load_en)
      sr_q <= frame_i;
    else if (shift_en)
      sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end

  assign bit_o = sr_q[FRAME_W-1];

endmodule

// File: rtl/dcd_phase_ctrl.sv
module dcd_phase_ctrl
  import dcd_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int CNT_W   = 8,
  localparam int BIT_W  = (FRAME_W > 1) ? $clog2(FRAME_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic [CNT_W-1:0] cfg_hi,
  input  logic [CNT_W-1:0] cfg_ld,
  output logic             sclk_o,
  output logic             load_n_o,
  output logic             busy_o,
  output logic             load_frame_o,
  output logic             shift_o,
  output logic             rise_evt_o,
  output logic             done_evt_o
);

  // A zero count would mean a phase with no cycles; treat it as one.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    eff_count = (c == '0) ? CNT_W'(1) : c;
  endfunction

  phase_e           ph_q;
  logic [CNT_W-1:0] tmr_q;
  logic [BIT_W-1:0] bit_q;
  logic             tmr_zero;
  logic             last_bit;

  assign tmr_zero     = (tmr_q == '0);
  assign last_bit     = (bit_q == BIT_W'(FRAME_W - 1));
  assign load_frame_o = (ph_q == PH_IDLE) && go;
  assign shift_o      = (ph_q == PH_HIGH) && tmr_zero;
  assign rise_evt_o   = (ph_q == PH_LOW) && tmr_zero;
  assign done_evt_o   = (ph_q == PH_LOAD) && tmr_zero;
  assign busy_o       = (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      tmr_q    <= '0;
      bit_q    <= '0;
      sclk_o   <= 1'b1;
      load_n_o <= 1'b1;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (go) begin
            ph_q   <= PH_LOW;
            sclk_o <= 1'b0;
            bit_q  <= '0;
            tmr_q  <= eff_count(cfg_lo) - CNT_W'(1);
          end
        end
        PH_LOW: begin
          if (tmr_zero) begin
            sclk_o <= 1'b1;
            if (last_bit) begin
              ph_q     <= PH_LOAD;
              load_n_o <= 1'b0;
              tmr_q    <= eff_count(cfg_ld) - CNT_W'(1);
            end else begin
              ph_q  <= PH_HIGH;
              tmr_q <= eff_count(cfg_hi) - CNT_W'(1);
            end
          end else begin
            tmr_q <= tmr_q - CNT_W'(1);
          end
        end
        PH_HIGH: begin
          if (tmr_zero) begin
            ph_q   <= PH_LOW;
            sclk_o <= 1'b0;
            bit_q  <= bit_q + BIT_W'(1);
            tmr_q  <= eff_count(cfg_lo) - CNT_W'(1);
          end else begin
            tmr_q <= tmr_q - CNT_W'(1);
          end
        end
        PH_LOAD: begin
          if (tmr_zero) begin
            ph_q     <= PH_IDLE;
            load_n_o <= 1'b1;
          end else begin
            tmr_q <= tmr_q - CNT_W'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dcd_chain_driver.sv
module dcd_chain_driver #(
  parameter int N_DEV  = 4,
  parameter int WORD_W = 12,
  parameter int CNT_W  = 8,
  localparam int FRAME_W = N_DEV * WORD_W,
  localparam int IDX_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_lo_cycles,
  input  logic [CNT_W-1:0]  cfg_hi_cycles,
  input  logic [CNT_W-1:0]  cfg_ld_cycles,
  input  logic              bipolar_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              start,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_load_n,
  output logic              busy
);

  logic [FRAME_W-1:0] frame_w;
  logic               load_frame_w;
  logic               shift_w;
  logic               rise_evt;
  logic               done_evt;
  logic               wr_take;

  assign wr_ready = ~busy;
  assign wr_take  = wr_valid & wr_ready;

  dcd_word_store #(
    .N_DEV  (N_DEV),
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_take),
    .wr_idx  (wr_idx),
    .wr_data (wr_word),
    .bipolar (bipolar_en),
    .frame_o (frame_w)
  );

  dcd_frame_shifter #(
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_frame_w),
    .frame_i  (frame_w),
    .shift_en (shift_w),
    .bit_o    (ser_data)
  );

  dcd_phase_ctrl #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (start),
    .cfg_lo       (cfg_lo_cycles),
    .cfg_hi       (cfg_hi_cycles),
    .cfg_ld       (cfg_ld_cycles),
    .sclk_o       (ser_clk),
    .load_n_o     (ser_load_n),
    .busy_o       (busy),
    .load_frame_o (load_frame_w),
    .shift_o      (shift_w),
    .rise_evt_o   (rise_evt),
    .done_evt_o   (done_evt)
  );

endmodule

// File: rtl/dcd_chain_driver_chk.sv
module dcd_chain_driver_chk #(
  parameter int FRAME_W = 48,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cfg_lo_cycles,
  input logic             ser_data,
  input logic             ser_clk,
  input logic             ser_load_n,
  input logic             busy,
  input logic             rise_evt,
  input logic             done_evt
);

  logic             sclk_d;
  logic             load_d;
  logic [CNT_W:0]   lo_run;
  logic [15:0]      rise_cnt;
  logic [CNT_W-1:0] lo_eff;

  assign lo_eff = (cfg_lo_cycles == '0) ? CNT_W'(1) : cfg_lo_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      load_d   <= 1'b1;
      lo_run   <= '0;
      rise_cnt <= '0;
    end else begin
      sclk_d   <= ser_clk;
      load_d   <= ser_load_n;
      lo_run   <= ser_clk ? '0 : lo_run + 1'b1;
      if (!busy)
        rise_cnt <= '0;
      else if (ser_clk && !sclk_d)
        rise_cnt <= rise_cnt + 16'd1;
    end
  end

  assert_data_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_data) |-> !ser_clk);

  assert_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !sclk_d) |-> (lo_run == {1'b0, lo_eff}));

  assert_rise_follows_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> ser_clk);

  assert_load_with_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_load_n) |-> $rose(ser_clk));

  assert_edge_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_load_n && load_d) |-> (rise_cnt == 16'(FRAME_W - 1)));

  assert_busy_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!busy && ser_load_n));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ser_clk && ser_load_n));

endmodule

bind dcd_chain_driver dcd_chain_driver_chk #(
  .FRAME_W (FRAME_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_lo_cycles (cfg_lo_cycles),
  .ser_data      (ser_data),
  .ser_clk       (ser_clk),
  .ser_load_n    (ser_load_n),
  .busy          (busy),
  .rise_evt      (rise_evt),
  .done_evt      (done_evt)
);

// File: tb/dcd_chain_driver_bench.sv
module dcd_chain_driver_bench;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic [47:0] words;
    logic        bip;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [7:0]  ld;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{48'hABC123F00055, 1'b0, 8'd2, 8'd1, 8'd3},
    '{48'h8007FF000FFF, 1'b1, 8'd1, 8'd1, 8'd1},
    '{48'h5A5A5A0F0F0F, 1'b0, 8'd0, 8'd0, 8'd0},
    '{48'h123456789ABC, 1'b1, 8'd3, 8'd2, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_lo_cycles = 8'd1, cfg_hi_cycles = 8'd1, cfg_ld_cycles = 8'd1;
  logic        bipolar_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_idx = '0;
  logic [11:0] wr_word = '0;
  logic        start = 1'b0;
  logic        ser_data, ser_clk, ser_load_n, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dcd_chain_driver u_dcd_chain_driver (
    .clk(clk), .rst_n(rst_n),
    .cfg_lo_cycles(cfg_lo_cycles), .cfg_hi_cycles(cfg_hi_cycles),
    .cfg_ld_cycles(cfg_ld_cycles), .bipolar_en(bipolar_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_word(wr_word),
    .start(start), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_load_n(ser_load_n), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] c);
    return (c == 8'd0) ? 1 : int'(c);
  endfunction

  task automatic write_word(input int idx, input logic [11:0] w);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = 2'(idx); wr_word = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] words, input logic bip,
                           input logic [7:0] lo, input logic [7:0] hi,
                           input logic [7:0] ld, input bit disturb);
    logic [47:0] exp_bits, mask, got;
    int rises = 0, lo_bad = 0, hi_bad = 0, ld_run = 0, ld_falls = 0;
    int align_bad = 0, r3_bad = 0, rdy_bad = 0, busy_cyc = 0;
    int low_run = 0, high_run = 0, exp_busy;
    logic p_clk, p_load, p_data;
    mask = '0;
    for (int k = 0; k < 4; k++) mask[k*12 + 11] = 1'b1;
    exp_bits = bip ? (words ^ mask) : words;
    exp_busy = 48*eff(lo) + 47*eff(hi) + eff(ld);
    got = '0;
    @(negedge clk);
    p_clk = ser_clk; p_load = ser_load_n; p_data = ser_data;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && busy_cyc < 20000) begin
      busy_cyc++;
      if (disturb && busy_cyc == 5) begin
        wr_valid = 1'b1; wr_idx = 2'd0; wr_word = ~words[11:0]; start = 1'b1;
      end else if (disturb && busy_cyc == 6) begin
        wr_valid = 1'b0; start = 1'b0;
      end
      if (wr_ready) rdy_bad++;
      if (ser_data != p_data && ser_clk) r3_bad++;
      if (!ser_clk) begin
        if (p_clk && rises > 0) begin
          if (high_run != eff(hi)) hi_bad++;
          high_run = 0;
        end
        low_run++;
      end else begin
        if (!p_clk) begin
          if (low_run != eff(lo)) lo_bad++;
          low_run = 0;
          got = {got[46:0], ser_data};
          rises++;
        end
        if (ser_load_n) high_run++;
      end
      if (!ser_load_n) begin
        ld_run++;
        if (p_load) begin
          ld_falls++;
          if (!(ser_clk && !p_clk) || rises != 48) align_bad++;
        end
      end
      p_clk = ser_clk; p_load = ser_load_n; p_data = ser_data;
      @(negedge clk);
    end
    check(got == exp_bits, "R2", "captured frame bits", got, exp_bits);
    check(rises == 48, "R2", "rising strobe edges", rises, 48);
    if (bip)
      check(got[47] == ~words[47] && got[36:35] == {words[36], ~words[35]},
            "R7", "sign bit inverted", got[47:35], exp_bits[47:35]);
    else
      check(got[47] == words[47], "R7", "sign bit kept", got[47], words[47]);
    check(r3_bad == 0, "R3", "data changed while strobe high", r3_bad, 0);
    check(lo_bad == 0 && hi_bad == 0, "R4", "strobe phase widths", lo_bad + hi_bad, 0);
    check(ld_run == eff(ld), "R5", "load pulse width", ld_run, eff(ld));
    check(ld_falls == 1 && align_bad == 0, "R5", "load aligned to last edge",
          ld_falls * 16 + align_bad, 16);
    check(busy_cyc == exp_busy, "R6", "busy duration", busy_cyc, exp_busy);
    check(rdy_bad == 0, "R6", "ready low while busy", rdy_bad, 0);
    check(ser_clk && ser_load_n && wr_ready, "R9", "idle levels after frame",
          {ser_clk, ser_load_n, wr_ready}, 3'b111);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected frame completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ser_clk && ser_load_n && !busy && wr_ready && !ser_data, "R1", "reset levels",
          {ser_clk, ser_load_n, busy, wr_ready, ser_data}, 5'b11010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ser_clk && ser_load_n && !busy, "R1", "levels after reset release",
          {ser_clk, ser_load_n, busy}, 3'b110);

    for (int v = 0; v < 4; v++) begin
      cfg_lo_cycles = VECS[v].lo; cfg_hi_cycles = VECS[v].hi;
      cfg_ld_cycles = VECS[v].ld; bipolar_en = VECS[v].bip;
      for (int k = 0; k < 4; k++) write_word(k, VECS[v].words[k*12 +: 12]);
      run_frame(VECS[v].words, VECS[v].bip, VECS[v].lo, VECS[v].hi, VECS[v].ld, 1'b0);
    end

    begin : idle_quiet_R9
      int bad = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (!ser_clk || !ser_load_n || busy) bad++;
      end
      check(bad == 0, "R9", "no activity while idle", bad, 0);
    end

    // R6 and R8: a write and a start offered mid-frame must change nothing.
    run_frame(VECS[3].words, VECS[3].bip, VECS[3].lo, VECS[3].hi, VECS[3].ld, 1'b1);
    run_frame(VECS[3].words, VECS[3].bip, VECS[3].lo, VECS[3].hi, VECS[3].ld, 1'b0);
    check(!busy, "R8", "no restart from start during frame", busy, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule